// File: doc/BRIEF.md
# Multiplexer-Based Parallel-to-Serial Converter

This block turns an 8-bit parallel word into a one-bit-per-clock serial stream without shifting the word. The word is first held in a register. A free-running binary counter drives the select lines of an 8-to-1 multiplexer, and the multiplexer's data inputs are the bits of the held word. The held word therefore never moves; only the selected bit position changes.

The counter steps once per clock and wraps from 7 to 0. The outputs are the selected bit, the current bit index and a one-cycle frame-start marker. A load request presented at any count is deferred, so the held word only changes at a frame boundary. This keeps every transmitted frame built from a single word. If several requests arrive within one frame, the most recent one wins.

Top module: `par2ser_mux`

## Requirements
- R1: `ser_o` equals bit `idx_o` of the held word, so that index 0 carries the least significant bit and index 7 carries the most significant bit.
- R2: `idx_o` advances by one on every clock and wraps from 7 to 0, so every bit lasts exactly one clock.
- R3: `frame_o` is high in exactly the cycles where `idx_o` is 0.
- R4: A load request (`load_i` high at a rising edge) sampled while `idx_o` is 7 writes `data_i` into the held word, and that word is sent starting with the next frame.
- R5: A load request sampled while `idx_o` is not 7 leaves the current frame's bits unchanged. Its data is kept and becomes the held word at the next 7-to-0 wrap.
- R6: When several requests arrive before a wrap, the data of the last request sampled is the word that is held.
- R7: While `rst_ni` is low, the counter and the held word are cleared and any pending request is dropped: `idx_o` = 0, `frame_o` = 1, `ser_o` = 0.
- R8: A request sampled while `idx_o` is 7 takes precedence over an earlier pending request from the same frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Parallel word to serialise |
| load_i | input | 1 | Load request for `data_i` |
| ser_o | output | 1 | Serial data bit |
| idx_o | output | 3 | Index of the bit currently on `ser_o` |
| frame_o | output | 1 | High while bit 0 of a frame is sent |

## Verification
A counter that skips or stalls shows up at once on `idx_o` and `frame_o`, within the same clock. A held word that is corrupted or updated mid-frame shows up on `ser_o` only when a wrong bit is selected, which can take up to 8 clocks. For that reason a reference model is compared against all three outputs on every clock. A request that is lost or applied with the wrong priority becomes visible over the full frame after the next wrap. For that reason the directed cases also check a complete frame for each load scenario.

// File: rtl/par2ser_pkg.sv
package par2ser_pkg;
  typedef enum logic [1:0] {
    LD_KEEP    = 2'd0,
    LD_DIRECT  = 2'd1,
    LD_PENDING = 2'd2
  } ld_src_e;
endpackage

// File: rtl/p2s_step_counter.sv
module p2s_step_counter #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] cnt_q;

  assign last_o = (cnt_q == LAST);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (last_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST) |=> (cnt_q == '0));
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/p2s_hold_reg.sv
module p2s_hold_reg
  import par2ser_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              commit_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] word_q, pend_data_q;
  logic              pend_q;
  ld_src_e           src;

  // Direct request at the boundary beats an older pending one.
  always_comb begin
    src = LD_KEEP;
    if (commit_i) begin
      if (load_i)      src = LD_DIRECT;
      else if (pend_q) src = LD_PENDING;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q      <= '0;
      pend_q      <= 1'b0;
      pend_data_q <= '0;
    end else begin
      unique case (src)
        LD_DIRECT:  word_q <= data_i;
        LD_PENDING: word_q <= pend_data_q;
        default:    word_q <= word_q;
      endcase
      if (commit_i) begin
        pend_q <= 1'b0;
      end else if (load_i) begin
        pend_q      <= 1'b1;
        pend_data_q <= data_i;
      end
    end
  end

  assign word_o = word_q;

  p_word_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(word_q));
  p_pend_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !commit_i) |=> (pend_q && pend_data_q == $past(data_i)));
  p_direct_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && load_i) |=> (word_q == $past(data_i)));
  p_pend_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> !pend_q);
endmodule

// File: rtl/p2s_bit_select.sv
module p2s_bit_select #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [CNT_W-1:0]  sel_i,
  output logic              bit_o
);
  logic [DATA_W-1:0] hit;

  for (genvar i = 0; i < DATA_W; i++) begin : g_leg
    assign hit[i] = word_i[i] & (sel_i == CNT_W'(i));
  end

  assign bit_o = |hit;
endmodule

// File: rtl/par2ser_mux.sv
module par2ser_mux #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              load_i,
  output logic              ser_o,
  output logic [CNT_W-1:0]  idx_o,
  output logic              frame_o
);
  logic [CNT_W-1:0]  cnt;
  logic              last;
  logic [DATA_W-1:0] word;

  p2s_step_counter #(.DATA_W(DATA_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt),
    .last_o (last)
  );

  p2s_hold_reg #(.DATA_W(DATA_W)) i_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .data_i   (data_i),
    .commit_i (last),
    .word_o   (word)
  );

  p2s_bit_select #(.DATA_W(DATA_W)) i_sel (
    .word_i (word),
    .sel_i  (cnt),
    .bit_o  (ser_o)
  );

  assign idx_o   = cnt;
  assign frame_o = (cnt == '0);

  p_frame_after_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> frame_o);
  p_frame_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |=> !frame_o);
  p_reset_clear_r7: assert property (@(posedge clk_i)
    !rst_ni |-> (idx_o == '0 && !ser_o && frame_o));
endmodule

// File: tb/test_par2ser_mux.sv
module test_par2ser_mux;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] data_i = '0;
  logic       load_i = 1'b0;
  logic       ser_o;
  logic [2:0] idx_o;
  logic       frame_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model
  int         m_cnt = 0;
  logic [7:0] m_word = '0;
  bit         m_pend = 0;
  logic [7:0] m_pdata = '0;

  always #2 clk = ~clk;

  par2ser_mux i_par2ser_mux (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data_i), .load_i(load_i),
    .ser_o(ser_o), .idx_o(idx_o), .frame_o(frame_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_word = '0; m_pend = 0; m_pdata = '0;
    end else begin
      if (m_cnt == 7) begin
        if (load_i) m_word = data_i;
        else if (m_pend) m_word = m_pdata;
        m_pend = 0;
        m_cnt = 0;
      end else begin
        if (load_i) begin m_pend = 1; m_pdata = data_i; end
        m_cnt = m_cnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk("R1 ser", int'(ser_o), int'(m_word[m_cnt]));
    chk("R2 idx", int'(idx_o), m_cnt);
    chk("R3 frame", int'(frame_o), int'(m_cnt == 0));
  endtask

  task automatic cycle(input bit ld, input logic [7:0] d);
    @(negedge clk);
    compare();
    load_i = ld;
    data_i = d;
  endtask

  task automatic go_to(input int k);
    do cycle(0, 8'h00); while (int'(idx_o) != k);
  endtask

  // Expects to be called at a negedge where idx_o == 0.
  task automatic check_frame(input logic [7:0] w, input string tag);
    for (int i = 0; i < 8; i++) begin
      chk(tag, int'(ser_o), int'(w[i]));
      chk(tag, int'(idx_o), i);
      cycle(0, 8'h00);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    lfsr = 8'h5B;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk("R7 idx", int'(idx_o), 0);
    chk("R7 frame", int'(frame_o), 1);
    chk("R7 ser", int'(ser_o), 0);
    rst_n = 1'b1;
    repeat (10) cycle(0, 8'h00);

    // R4 load at count 7
    go_to(7); load_i = 1; data_i = 8'hA5;
    cycle(0, 8'h00);
    check_frame(8'hA5, "R4");

    // R5 deferred load
    go_to(3); load_i = 1; data_i = 8'h3C;
    cycle(0, 8'h00);
    go_to(0);
    check_frame(8'h3C, "R5");

    // R6 latest pending wins
    go_to(1); load_i = 1; data_i = 8'h11;
    go_to(4); load_i = 1; data_i = 8'h22;
    go_to(0);
    check_frame(8'h22, "R6");

    // R8 request at count 7 overrides pending
    go_to(2); load_i = 1; data_i = 8'h44;
    go_to(7); load_i = 1; data_i = 8'h99;
    cycle(0, 8'h00);
    check_frame(8'h99, "R8");

    // mixed traffic
    for (int n = 0; n < 1500; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cycle(lfsr[0] & lfsr[3], lfsr ^ 8'(n));
    end

    // R7 reset mid-frame drops pending request
    go_to(2); load_i = 1; data_i = 8'hF0;
    cycle(0, 8'h00);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R7 idx", int'(idx_o), 0);
    chk("R7 ser", int'(ser_o), 0);
    rst_n = 1'b1;
    go_to(7);
    cycle(0, 8'h00);
    check_frame(8'h00, "R7");

    repeat (20) cycle(0, 8'h00);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule